// File: doc/BRIEF.md
# Subroutine-Scoped Status and Mode Register

This block keeps a processor's carry flag and its carry-enable mode bit. It also holds a small last-in-first-out store that saves the status word across subroutine calls. A call command saves the whole status word and then clears the mode bit, so every new subroutine level starts with carry-in disabled. Two kinds of return are offered. A loading return pops the saved word back into the register, so the caller gets its own mode and carry again. A dropping return pops the saved word and throws it away, so the caller sees the carry and mode the callee left behind.

A registered add/subtract unit sits beside the register. The mode bit decides whether the carry flag feeds its carry-in. The unit writes its carry-out back into the carry flag. There are also explicit set and clear commands for both bits. Two sticky error flags report a call made while the store is full and a return made while it is empty.

Top module: `scoped_status_reg`

## Requirements
- R1: A call pushes the current status word {mode, carry} onto the status store, which holds DEPTH entries (default 8). A later loading return brings back exactly that word.
- R2: A call that is accepted clears the mode bit at the clock edge and leaves the carry bit as it was.
- R3: A loading return on a non-empty store pops the top word and writes it into the status register, both the mode and the carry bit.
- R4: A dropping return on a non-empty store pops the top word and discards it. Mode and carry keep the values they had before the return.
- R5: Addition (op_valid_i high, op_sub_i low) gives res_o = a + b + cin, with cin = carry when mode is 1 and cin = 0 when mode is 0. The carry flag takes bit W of the sum. res_o and the carry are updated at the clock edge that samples op_valid_i, and res_valid_o is high for the one cycle that follows.
- R6: Subtraction (op_sub_i high) gives res_o = a + ~b + cin, with cin = carry when mode is 1 and cin = 1 when mode is 0. The carry flag takes the not-borrow (1 when no borrow occurred).
- R7: After reset the status word is all zero, the store is empty, both sticky flags are 0 and res_valid_o is 0.
- R8: A call while DEPTH words are stored sets stk_ovf_o, which then stays set until reset. The store contents and the status word do not change.
- R9: A return of either kind on an empty store sets stk_unf_o, which then stays set until reset. The status word does not change.
- R10: Call beats loading return, and loading return beats dropping return. A cycle with any of these commands ignores the mode and carry set/clear commands and the adder's carry update for that cycle. The adder's result is still registered.
- R11: Without a stack command, mode_set_i beats mode_clr_i and carry_set_i beats carry_clr_i. An explicit carry command beats the adder's carry update.
- R12: status_o has carry at bit 0 and mode at bit 1. All higher bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Subroutine call: save status, clear mode |
| ret_load_i | input | 1 | Return that restores the saved status |
| ret_drop_i | input | 1 | Return that discards the saved status |
| mode_set_i | input | 1 | Set the carry-enable mode bit |
| mode_clr_i | input | 1 | Clear the carry-enable mode bit |
| carry_set_i | input | 1 | Set the carry flag |
| carry_clr_i | input | 1 | Clear the carry flag |
| op_valid_i | input | 1 | Start an add or subtract this cycle |
| op_sub_i | input | 1 | 1 = subtract, 0 = add |
| op_a_i | input | W | First operand |
| op_b_i | input | W | Second operand |
| status_o | output | STATUS_W | Status word: bit 0 carry, bit 1 mode |
| res_o | output | W | Registered add/subtract result |
| res_valid_o | output | 1 | Result registered in the previous cycle |
| stk_ovf_o | output | 1 | Sticky: call made while the store was full |
| stk_unf_o | output | 1 | Sticky: return made while the store was empty |

## Verification
A corrupted stored entry stays hidden until the matching loading return. It then appears on status_o in the cycle after that return, which may be many calls deep. So the bench nests calls up to full depth with a different mode and carry at each level, and unwinds them one at a time. A wrong mode bit shows at status_o right after the edge. It also shows one cycle later as a result off by one in res_o, because the mode decides the carry-in. A miscounted store pointer shows as a sticky flag that rises one call or return too early or too late.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // Saved and live status: bit 1 mode, bit 0 carry
  typedef struct packed {
    logic mode;
    logic carry;
  } stat_t;

  localparam int STAT_BITS = 2;

  typedef enum logic [1:0] {
    STK_NONE = 2'd0,
    STK_CALL = 2'd1,
    STK_LOAD = 2'd2,
    STK_DROP = 2'd3
  } stk_act_e;

  // Carry-in seen by the adder: carry when enabled, else the neutral value
  function automatic logic gated_cin(input logic sub, input stat_t st);
    return st.mode ? st.carry : sub;
  endfunction

endpackage

// File: rtl/ssr_addsub.sv
module ssr_addsub
  import ssr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic         op_sub,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  stat_t        st,
  output logic         cout_nx,
  output logic [W-1:0] res_q,
  output logic         res_valid_q
);

  localparam int SW = W + 1;

  function automatic logic [SW-1:0] addsub(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic         sub,
                                           input logic         cin);
    logic [W-1:0] bx;
    bx = sub ? ~b : b;
    return {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
  endfunction

  logic          cin_w;
  logic [SW-1:0] sum_w;

  assign cin_w   = gated_cin(op_sub, st);
  assign sum_w   = addsub(op_a, op_b, op_sub, cin_w);
  assign cout_nx = sum_w[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= op_valid;
      if (op_valid) res_q <= sum_w[W-1:0];
    end
  end

  AST_ADD_NEUTRAL_CIN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sub && !st.mode && op_b == '0) |=> res_q == $past(op_a)); // R5
  AST_SUB_NEUTRAL_CIN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sub && !st.mode && op_b == '0) |=> res_q == $past(op_a)); // R6
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid_q); // R5

endmodule

// File: rtl/ssr_stack.sv
module ssr_stack
  import ssr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  logic  pop,
  input  stat_t push_data,
  output stat_t top_data,
  output logic  full,
  output logic  empty
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q;
  stat_t         mem_q [DEPTH];
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] top_idx;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_idx  = IW'(cnt_q);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign top_data = empty ? stat_t'('0) : mem_q[top_idx];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic we;
    assign we = push && !full && (wr_idx == IW'(gi));
    always_ff @(posedge clk) begin
      if (!rst_n)  mem_q[gi] <= '0;
      else if (we) mem_q[gi] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (push && !full)    cnt_q <= cnt_q + CW'(1);
    else if (pop && !empty)    cnt_q <= cnt_q - CW'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R1
  AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> cnt_q == $past(cnt_q)); // R8
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> empty); // R9
  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R10

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  call,
  input  logic  ret_load,
  input  logic  ret_drop,
  input  logic  mode_set,
  input  logic  mode_clr,
  input  logic  carry_set,
  input  logic  carry_clr,
  input  logic  op_valid,
  input  logic  alu_cout,
  input  logic  stk_full,
  input  logic  stk_empty,
  input  stat_t stk_top,
  output stat_t stat_q,
  output logic  stk_push,
  output logic  stk_pop,
  output logic  ovf_q,
  output logic  unf_q,
  output logic  ev_push,
  output logic  ev_pop_load,
  output logic  ev_pop_drop,
  output logic  ev_ovf,
  output logic  ev_unf
);

  stk_act_e act;
  stat_t    stat_nx;

  always_comb begin
    if (call)          act = STK_CALL;
    else if (ret_load) act = STK_LOAD;
    else if (ret_drop) act = STK_DROP;
    else               act = STK_NONE;
  end

  assign ev_push     = (act == STK_CALL) && !stk_full;
  assign ev_ovf      = (act == STK_CALL) && stk_full;
  assign ev_pop_load = (act == STK_LOAD) && !stk_empty;
  assign ev_pop_drop = (act == STK_DROP) && !stk_empty;
  assign ev_unf      = ((act == STK_LOAD) || (act == STK_DROP)) && stk_empty;

  assign stk_push = ev_push;
  assign stk_pop  = ev_pop_load || ev_pop_drop;

  always_comb begin
    stat_nx = stat_q;
    if (act != STK_NONE) begin
      if (ev_push)     stat_nx.mode = 1'b0;
      if (ev_pop_load) stat_nx = stk_top;
    end else begin
      if (mode_set)       stat_nx.mode = 1'b1;
      else if (mode_clr)  stat_nx.mode = 1'b0;
      if (carry_set)      stat_nx.carry = 1'b1;
      else if (carry_clr) stat_nx.carry = 1'b0;
      else if (op_valid)  stat_nx.carry = alu_cout;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      if (ev_ovf) ovf_q <= 1'b1;
      if (ev_unf) unf_q <= 1'b1;
    end
  end

  AST_CALL_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> !stat_q.mode); // R2
  AST_CALL_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> stat_q.carry == $past(stat_q.carry)); // R2
  AST_RET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_load |=> stat_q == $past(stk_top)); // R3
  AST_RET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_drop |=> stat_q == $past(stat_q)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R8
  AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> stat_q == $past(stat_q)); // R8
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |=> unf_q); // R9
  AST_UNF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> stat_q == $past(stat_q)); // R9
  AST_CALL_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (call && mode_set && !stk_full) |=> !stat_q.mode); // R10
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!call && !ret_load && !ret_drop && carry_set) |=> stat_q.carry); // R11

endmodule

// File: rtl/scoped_status_reg.sv
module scoped_status_reg
  import ssr_pkg::*;
#(
  parameter int W        = 16,
  parameter int DEPTH    = 8,
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                call_i,
  input  logic                ret_load_i,
  input  logic                ret_drop_i,
  input  logic                mode_set_i,
  input  logic                mode_clr_i,
  input  logic                carry_set_i,
  input  logic                carry_clr_i,
  input  logic                op_valid_i,
  input  logic                op_sub_i,
  input  logic [W-1:0]        op_a_i,
  input  logic [W-1:0]        op_b_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [W-1:0]        res_o,
  output logic                res_valid_o,
  output logic                stk_ovf_o,
  output logic                stk_unf_o
);

  localparam int RSV_W = STATUS_W - STAT_BITS;

  stat_t stat_w;
  stat_t stk_top_w;
  logic  stk_full_w, stk_empty_w, stk_push_w, stk_pop_w;
  logic  alu_cout_w;
  logic  ev_push, ev_pop_load, ev_pop_drop, ev_ovf, ev_unf;

  ssr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .call       (call_i),
    .ret_load   (ret_load_i),
    .ret_drop   (ret_drop_i),
    .mode_set   (mode_set_i),
    .mode_clr   (mode_clr_i),
    .carry_set  (carry_set_i),
    .carry_clr  (carry_clr_i),
    .op_valid   (op_valid_i),
    .alu_cout   (alu_cout_w),
    .stk_full   (stk_full_w),
    .stk_empty  (stk_empty_w),
    .stk_top    (stk_top_w),
    .stat_q     (stat_w),
    .stk_push   (stk_push_w),
    .stk_pop    (stk_pop_w),
    .ovf_q      (stk_ovf_o),
    .unf_q      (stk_unf_o),
    .ev_push    (ev_push),
    .ev_pop_load(ev_pop_load),
    .ev_pop_drop(ev_pop_drop),
    .ev_ovf     (ev_ovf),
    .ev_unf     (ev_unf)
  );

  ssr_stack #(.DEPTH(DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (stk_push_w),
    .pop      (stk_pop_w),
    .push_data(stat_w),
    .top_data (stk_top_w),
    .full     (stk_full_w),
    .empty    (stk_empty_w)
  );

  ssr_addsub #(.W(W)) u_alu (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid_i),
    .op_sub     (op_sub_i),
    .op_a       (op_a_i),
    .op_b       (op_b_i),
    .st         (stat_w),
    .cout_nx    (alu_cout_w),
    .res_q      (res_o),
    .res_valid_q(res_valid_o)
  );

  assign status_o = {{RSV_W{1'b0}}, stat_w};

  AST_PUSH_SAVES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> stk_top_w == $past(stat_w)); // R1
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[STATUS_W-1:STAT_BITS] == '0); // R12
  AST_ONE_STACK_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_push, ev_pop_load, ev_pop_drop, ev_ovf, ev_unf})); // R10

endmodule

// File: tb/scoped_status_reg_tb.sv
`timescale 1ns/1ps
module scoped_status_reg_tb;

  localparam int W  = 16;
  localparam int D  = 8;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_i = 0, ret_load_i = 0, ret_drop_i = 0;
  logic mode_set_i = 0, mode_clr_i = 0, carry_set_i = 0, carry_clr_i = 0;
  logic op_valid_i = 0, op_sub_i = 0;
  logic [W-1:0] op_a_i = '0, op_b_i = '0;
  logic [SW-1:0] status_o;
  logic [W-1:0]  res_o;
  logic res_valid_o, stk_ovf_o, stk_unf_o;

  always #2.5 clk = ~clk;

  scoped_status_reg #(.W(W), .DEPTH(D), .STATUS_W(SW)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference state
  bit m_mode, m_carry, m_ovf, m_unf, m_rv;
  bit [1:0] m_stk [D];
  int m_sp;
  bit [W-1:0] m_res;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference arithmetic written as signed integer math
  function automatic bit [W:0] ref_alu(input bit [W-1:0] a, input bit [W-1:0] b,
                                       input bit sub, input bit md, input bit cy);
    longint r;
    if (!sub) begin
      r = longint'(a) + longint'(b) + ((md && cy) ? 1 : 0);
      return {r > longint'((1 << W) - 1), r[W-1:0]};
    end
    r = longint'(a) - longint'(b) - ((md && !cy) ? 1 : 0);
    return {r >= 0, r[W-1:0]};
  endfunction

  task automatic model_reset();
    m_mode = 0; m_carry = 0; m_ovf = 0; m_unf = 0; m_rv = 0; m_sp = 0; m_res = '0;
  endtask

  task automatic check_all(input string req);
    chk(req, status_o, {6'b0, m_mode, m_carry});
    chk(req, stk_ovf_o, m_ovf);
    chk(req, stk_unf_o, m_unf);
    chk(req, res_valid_o, m_rv);
    if (m_rv) chk(req, res_o, m_res);
  endtask

  // One cycle: drive, predict, clock, compare
  task automatic cyc(input string req, input bit c, input bit rl, input bit rd,
                     input bit ms, input bit mc, input bit cs, input bit cc,
                     input bit ov, input bit sb, input bit [W-1:0] a, input bit [W-1:0] b);
    bit [W:0] alu;
    bit stk;
    call_i = c; ret_load_i = rl; ret_drop_i = rd;
    mode_set_i = ms; mode_clr_i = mc; carry_set_i = cs; carry_clr_i = cc;
    op_valid_i = ov; op_sub_i = sb; op_a_i = a; op_b_i = b;
    alu = ref_alu(a, b, sb, m_mode, m_carry);
    m_rv = ov;
    if (ov) m_res = alu[W-1:0];
    stk = c | rl | rd;
    if (c) begin
      if (m_sp == D) m_ovf = 1;
      else begin m_stk[m_sp] = {m_mode, m_carry}; m_sp++; m_mode = 0; end
    end else if (rl || rd) begin
      if (m_sp == 0) m_unf = 1;
      else begin
        m_sp--;
        if (rl) {m_mode, m_carry} = m_stk[m_sp];
      end
    end
    if (!stk) begin
      if (ms) m_mode = 1; else if (mc) m_mode = 0;
      if (cs) m_carry = 1; else if (cc) m_carry = 0; else if (ov) m_carry = alu[W];
    end
    @(posedge clk); #1;
    call_i = 0; ret_load_i = 0; ret_drop_i = 0; mode_set_i = 0; mode_clr_i = 0;
    carry_set_i = 0; carry_clr_i = 0; op_valid_i = 0;
    check_all(req);
  endtask

  task automatic idle(input string req);
    cyc(req, 0,0,0, 0,0,0,0, 0,0, '0, '0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check_all("R7");
    rst_n = 1;
    idle("R7");

    // R12 layout and R11 priority of set over clear
    cyc("R11", 0,0,0, 1,1,1,1, 0,0, '0, '0);
    chk("R12", status_o, 8'h03);
    // explicit carry beats adder carry
    cyc("R11", 0,0,0, 0,0,0,1, 1,0, 16'hFFFF, 16'h0001);

    // R5 add, mode clear ignores carry; then mode set uses it
    cyc("R5", 0,0,0, 0,0,1,0, 0,0, '0, '0);
    cyc("R11", 0,0,0, 0,1,0,0, 0,0, '0, '0);
    cyc("R5", 0,0,0, 0,0,0,0, 1,0, 16'h1234, 16'h0001);
    cyc("R5", 0,0,0, 1,0,1,0, 0,0, '0, '0);
    cyc("R5", 0,0,0, 0,0,0,0, 1,0, 16'hFFFF, 16'h0000);
    cyc("R5", 0,0,0, 0,0,0,0, 1,0, 16'h0001, 16'h0001);
    // R6 subtract, both modes, borrow cases
    cyc("R6", 0,0,0, 0,1,0,1, 1,1, 16'h0005, 16'h0005);
    cyc("R6", 0,0,0, 0,0,0,0, 1,1, 16'h0003, 16'h0005);
    cyc("R6", 0,0,0, 1,0,0,1, 0,0, '0, '0);
    cyc("R6", 0,0,0, 0,0,0,0, 1,1, 16'h0005, 16'h0005);

    // R1/R2/R3: mode=1 carry=1, call clears mode keeps carry, load restores
    cyc("R2", 0,0,0, 1,0,1,0, 0,0, '0, '0);
    cyc("R2", 1,0,0, 0,0,0,0, 0,0, '0, '0);
    cyc("R2", 0,0,0, 0,0,0,1, 0,0, '0, '0);
    cyc("R3", 0,1,0, 0,0,0,0, 0,0, '0, '0);
    chk("R1", status_o, 8'h03);
    // R4: drop keeps callee flags
    cyc("R4", 1,0,0, 0,0,0,0, 0,0, '0, '0);
    cyc("R4", 0,0,0, 0,0,0,1, 0,0, '0, '0);
    cyc("R4", 0,0,1, 0,0,0,0, 0,0, '0, '0);
    chk("R4", status_o, 8'h00);

    // R10: call beats set mode and adder carry; load beats drop
    cyc("R10", 0,0,0, 1,0,0,1, 0,0, '0, '0);
    cyc("R10", 1,0,0, 1,0,1,0, 1,0, 16'hFFFF, 16'h0001);
    cyc("R10", 0,1,1, 0,0,0,0, 0,0, '0, '0);
    chk("R10", status_o, 8'h02);

    // R8: fill the store with varied words, then overflow
    for (int i = 0; i < D; i++) begin
      cyc("R1", 0,0,0, i[0],!i[0], i[1],!i[1], 0,0, '0, '0);
      cyc("R1", 1,0,0, 0,0,0,0, 0,0, '0, '0);
    end
    cyc("R8", 0,0,0, 1,0,1,0, 0,0, '0, '0);
    cyc("R8", 1,0,0, 0,0,0,0, 0,0, '0, '0);
    chk("R8", stk_ovf_o, 1);
    idle("R8");
    // unwind: each load brings back its own word (R1, R3)
    for (int i = 0; i < D; i++) cyc("R3", 0,1,0, 0,0,0,0, 0,0, '0, '0);
    // R9: return on empty
    cyc("R9", 0,0,0, 1,0,0,1, 0,0, '0, '0);
    cyc("R9", 0,0,1, 0,0,0,0, 0,0, '0, '0);
    chk("R9", stk_unf_o, 1);
    cyc("R9", 0,1,0, 0,0,0,0, 0,0, '0, '0);

    // Reset clears sticky flags again (R7)
    rst_n = 0; model_reset();
    @(posedge clk); #1;
    check_all("R7");
    rst_n = 1;

    // Constrained random mix (R10 covers all rules together)
    void'($urandom(32'd20240517));
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 15);
      cyc("R10", k == 0 || k == 1, k == 2, k == 3,
          $urandom_range(0,3) == 0, $urandom_range(0,3) == 0,
          $urandom_range(0,3) == 0, $urandom_range(0,3) == 0,
          $urandom_range(0,1) == 1, $urandom_range(0,1) == 1,
          W'($urandom), ($urandom_range(0,3) == 0) ? '0 : W'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule